// File: doc/BRIEF.md
# Floating Point Exception and Status Unit

This block keeps the status word of a floating point unit together with the six exception mask bits of its control word. The arithmetic datapath reports each finished operation as an event. An event can carry any mix of three things: exception conditions, a register stack fault with its direction, and a comparison outcome. The unit collects exception conditions into sticky flags and sets them whatever the masks say. It derives an error summary bit from the flags and raises a registered interrupt request whenever a flag is set while its mask bit is clear. It also turns comparison outcomes into condition bits.

Events enter through a valid/ready interface. `ev_ready` is high except in a cycle where `clr_exc` or `init` is asserted. In such a cycle the event is not taken, and the producer must hold `ev_valid` and its payload until it sees `ev_ready` high at a rising edge. An event is consumed at the rising edge where `ev_valid && ev_ready` is true. The top-of-stack field, the busy bit, mask writes, clear and initialise are plain level pins sampled at each edge.

The status word is laid out as follows:
- bits 5:0 hold the flags: invalid (0), denormal (1), zero divide (2), overflow (3), underflow (4), precision (5).
- bit 6 is the stack fault and bit 7 is the error summary.
- the condition bits sit at C0 = bit 8, C1 = bit 9, C2 = bit 10 and C3 = bit 14.
- bits 13:11 hold the top-of-stack field and bit 15 is busy.

Top module: `fsu_status_unit`

## Requirements
- R1: After reset the status word reads 0x0000 (with `top_in`=0 and `busy_in`=0), `mask_out` reads 0x3F, `irq` is 0 and `ev_ready` is 1.
- R2: An accepted event ORs `ev_exc[5:0]` into status bits 5:0 at the accepting edge, whatever the mask bits hold.
- R3: Flags are sticky. An accepted event with no exception bits leaves them unchanged, and they only drop through `clr_exc` or `init`.
- R4: Status bit 7 is the OR of status bits 5:0.
- R5: An accepted event with `ev_stk_fault`=1 sets status bit 6 and the invalid flag (bit 0). It writes C1 (bit 9) with `ev_stk_dir`, where 1 means overflow and 0 means underflow.
- R6: An accepted event with `ev_cmp_en`=1 writes C3,C2,C0. `ev_cmp_res` 0 (greater) gives 0,0,0; 1 (less) gives 0,0,1; 2 (equal) gives 1,0,0; 3 (unordered) gives 1,1,1. C1 is written 0 unless the same event reports a stack fault. Events with neither a compare nor a fault leave C3..C0 unchanged.
- R7: `irq` is the OR over i of (flag[i] AND NOT mask[i]) and is registered. It rises one edge after the flag or mask value that causes it becomes visible.
- R8: `clr_exc` zeroes status bits 7:0 and `irq` at the next edge. The condition bits and masks are left unchanged.
- R9: `init` zeroes status bits 7:0, the condition bits and `irq`, and loads `mask_out` with 0x3F, all at the next edge.
- R10: `ev_ready` is 0 while `clr_exc` or `init` is 1. An event offered then is not applied, and it is applied once it is held into a cycle with `ev_ready`=1.
- R11: Status bits 13:11 and bit 15 show `top_in` and `busy_in` as sampled at the previous edge.
- R12: `mask_wr` loads `mask_in` into `mask_out` at the next edge. Clearing the mask of a flag that is already set raises `irq` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | An operation event is offered |
| ev_ready | output | 1 | Event accepted at this edge if valid |
| ev_exc | input | 6 | Exception conditions, same bit order as the flags |
| ev_stk_fault | input | 1 | Register stack fault reported |
| ev_stk_dir | input | 1 | Fault direction: 1 overflow, 0 underflow |
| ev_cmp_en | input | 1 | Event carries a comparison outcome |
| ev_cmp_res | input | 2 | 0 greater, 1 less, 2 equal, 3 unordered |
| top_in | input | 3 | Current top-of-stack index |
| busy_in | input | 1 | Datapath busy |
| mask_wr | input | 1 | Load exception masks |
| mask_in | input | 6 | New mask bits, 1 suppresses the interrupt |
| clr_exc | input | 1 | Clear exception flags and interrupt |
| init | input | 1 | Initialise status and masks |
| status_word | output | 16 | Status word read-back |
| mask_out | output | 6 | Current exception masks |
| irq | output | 1 | Interrupt request |

## Verification
The bench raises flags while every mask is set and checks that the flags appear but `irq` stays low. A design that gated the flags by the masks would lose them, and one that ignored the masks would interrupt. It unmasks an already-set flag and expects `irq` exactly one edge after the new mask shows. It offers an event in the same cycle as a clear and expects the event to be held back and applied afterwards; a design that dropped it or let it slip past the clear would show the wrong flags. It also drives all four compare outcomes and faults in both directions. This catches swapped condition bits, a C1 that is not driven by the direction, and a clear that wrongly wipes the condition bits.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  localparam int NUM_EXC = 6;
  localparam int TOP_W   = 3;
  localparam int SW_W    = 16;
  localparam int INV_BIT = 0;
  localparam logic [NUM_EXC-1:0] MASK_RST = '1;

  typedef enum logic [1:0] {
    CMP_GT = 2'd0,
    CMP_LT = 2'd1,
    CMP_EQ = 2'd2,
    CMP_UN = 2'd3
  } cmp_res_e;

  typedef struct packed {
    logic c3;
    logic c2;
    logic c1;
    logic c0;
  } ccode_t;

  function automatic ccode_t enc_cmp(cmp_res_e r);
    ccode_t c;
    c = '0;
    case (r)
      CMP_GT: begin c.c3 = 1'b0; c.c2 = 1'b0; c.c0 = 1'b0; end
      CMP_LT: begin c.c3 = 1'b0; c.c2 = 1'b0; c.c0 = 1'b1; end
      CMP_EQ: begin c.c3 = 1'b1; c.c2 = 1'b0; c.c0 = 1'b0; end
      default: begin c.c3 = 1'b1; c.c2 = 1'b1; c.c0 = 1'b1; end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/fsu_flags.sv
module fsu_flags
  import fsu_pkg::*;
#(
  parameter int N = NUM_EXC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_i,
  input  logic         clr_i,
  input  logic         take_i,
  input  logic [N-1:0] exc_i,
  input  logic         sf_i,
  output logic [N-1:0] flags_o,
  output logic         sf_o
);
  logic [N-1:0] flags_q;
  logic         sf_q;
  logic [N-1:0] fault_vec;

  always_comb begin
    fault_vec = '0;
    fault_vec[INV_BIT] = sf_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      sf_q    <= 1'b0;
    end else if (init_i || clr_i) begin
      flags_q <= '0;
      sf_q    <= 1'b0;
    end else if (take_i) begin
      flags_q <= flags_q | exc_i | fault_vec;
      sf_q    <= sf_q | sf_i;
    end
  end

  assign flags_o = flags_q;
  assign sf_o    = sf_q;

  // R3: without clear or init no flag ever drops
  assert_flags_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !clr_i) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R2: accepted exception bits are present after the edge
  assert_flags_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !init_i && !clr_i) |=> ((flags_q & $past(exc_i)) == $past(exc_i)));

  // R8: clear empties flags and fault
  assert_clear_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (flags_q == '0 && !sf_q));
endmodule

// File: rtl/fsu_ccode.sv
module fsu_ccode
  import fsu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   init_i,
  input  logic   take_i,
  input  logic   cmp_en_i,
  input  logic [1:0] cmp_i,
  input  logic   sf_i,
  input  logic   sf_dir_i,
  output ccode_t cc_o
);
  ccode_t cc_q;
  ccode_t cc_d;
  ccode_t cmp_code;

  assign cmp_code = enc_cmp(cmp_res_e'(cmp_i));

  always_comb begin
    cc_d = cc_q;
    if (take_i) begin
      if (cmp_en_i) begin
        cc_d.c3 = cmp_code.c3;
        cc_d.c2 = cmp_code.c2;
        cc_d.c0 = cmp_code.c0;
        cc_d.c1 = 1'b0;
      end
      if (sf_i) cc_d.c1 = sf_dir_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cc_q <= '0;
    else if (init_i) cc_q <= '0;
    else             cc_q <= cc_d;
  end

  assign cc_o = cc_q;

  // R6: an equal compare reads C3=1 C2=0 C0=0
  assert_cmp_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && cmp_en_i && cmp_i == 2'd2 && !init_i) |=> (cc_q.c3 && !cc_q.c2 && !cc_q.c0));

  // R5: fault direction lands in C1
  assert_fault_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && sf_i && !init_i) |=> (cc_q.c1 == $past(sf_dir_i)));

  // R9: initialise zeroes condition bits
  assert_init_cc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (cc_q == '0));
endmodule

// File: rtl/fsu_irq.sv
module fsu_irq
  import fsu_pkg::*;
#(
  parameter int N = NUM_EXC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_i,
  input  logic         clr_i,
  input  logic         mask_wr_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] flags_i,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] mask_q;
  logic [N-1:0] pend;
  logic         irq_q;

  for (genvar i = 0; i < N; i++) begin : g_pend
    assign pend[i] = flags_i[i] & ~mask_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= MASK_RST;
    else if (init_i)    mask_q <= MASK_RST;
    else if (mask_wr_i) mask_q <= mask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                irq_q <= 1'b0;
    else if (init_i || clr_i)  irq_q <= 1'b0;
    else                       irq_q <= |pend;
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  // R7: nothing unmasked pending means no request next cycle
  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_i & ~mask_q) == '0) |=> !irq_q);

  // R7: an unmasked pending flag raises the request next cycle
  assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (((flags_i & ~mask_q) != '0) && !init_i && !clr_i) |=> irq_q);

  // R9: initialise restores all-masked state
  assert_init_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (mask_q == MASK_RST && !irq_q));
endmodule

// File: rtl/fsu_status_unit.sv
module fsu_status_unit
  import fsu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_valid,
  output logic        ev_ready,
  input  logic [5:0]  ev_exc,
  input  logic        ev_stk_fault,
  input  logic        ev_stk_dir,
  input  logic        ev_cmp_en,
  input  logic [1:0]  ev_cmp_res,
  input  logic [2:0]  top_in,
  input  logic        busy_in,
  input  logic        mask_wr,
  input  logic [5:0]  mask_in,
  input  logic        clr_exc,
  input  logic        init,
  output logic [15:0] status_word,
  output logic [5:0]  mask_out,
  output logic        irq
);
  logic [NUM_EXC-1:0] flags;
  logic               sf;
  ccode_t             cc;
  logic [TOP_W-1:0]   top_q;
  logic               busy_q;
  logic               take;
  logic               err_sum;

  assign ev_ready = !(clr_exc || init);
  assign take     = ev_valid && ev_ready;

  fsu_flags #(.N(NUM_EXC)) u_flags (
    .clk(clk), .rst_n(rst_n), .init_i(init), .clr_i(clr_exc),
    .take_i(take), .exc_i(ev_exc), .sf_i(ev_stk_fault),
    .flags_o(flags), .sf_o(sf)
  );

  fsu_ccode u_cc (
    .clk(clk), .rst_n(rst_n), .init_i(init), .take_i(take),
    .cmp_en_i(ev_cmp_en), .cmp_i(ev_cmp_res),
    .sf_i(ev_stk_fault), .sf_dir_i(ev_stk_dir), .cc_o(cc)
  );

  fsu_irq #(.N(NUM_EXC)) u_irq (
    .clk(clk), .rst_n(rst_n), .init_i(init), .clr_i(clr_exc),
    .mask_wr_i(mask_wr), .mask_i(mask_in), .flags_i(flags),
    .mask_o(mask_out), .irq_o(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      top_q  <= top_in;
      busy_q <= busy_in;
    end
  end

  assign err_sum = |flags;

  assign status_word = {busy_q, cc.c3, top_q, cc.c2, cc.c1, cc.c0,
                        err_sum, sf, flags};

  // R10: no event is accepted while a clear or initialise is applied
  assert_ready_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_exc || init) |-> !ev_ready);

  // R4: summary bit follows the flags
  assert_summary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[7] == (status_word[5:0] != 6'd0));

  // R11: top field follows its input one edge later
  assert_top_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_word[13:11] == $past(top_in)));
endmodule

// File: tb/sim_fsu_status_unit.sv
`timescale 1ns/1ps
module sim_fsu_status_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 0, ev_stk_fault = 0, ev_stk_dir = 0, ev_cmp_en = 0;
  logic [5:0] ev_exc = '0;
  logic [1:0] ev_cmp_res = '0;
  logic [2:0] top_in = '0;
  logic busy_in = 0, mask_wr = 0, clr_exc = 0, init = 0;
  logic [5:0] mask_in = '0;
  logic ev_ready, irq;
  logic [15:0] status_word;
  logic [5:0] mask_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model of visible state
  logic [5:0] m_flags = '0;
  logic m_sf = 0;
  logic [3:0] m_cc = '0; // c3 c2 c1 c0

  always #2 clk = ~clk;

  fsu_status_unit u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_exc(ev_exc), .ev_stk_fault(ev_stk_fault), .ev_stk_dir(ev_stk_dir),
    .ev_cmp_en(ev_cmp_en), .ev_cmp_res(ev_cmp_res), .top_in(top_in),
    .busy_in(busy_in), .mask_wr(mask_wr), .mask_in(mask_in),
    .clr_exc(clr_exc), .init(init), .status_word(status_word),
    .mask_out(mask_out), .irq(irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] low_byte();
    return {|m_flags, m_sf, m_flags};
  endfunction

  function automatic logic [3:0] cc_of(logic [15:0] s);
    return {s[14], s[10], s[9], s[8]};
  endfunction

  task automatic send(logic [5:0] exc, logic sf, logic dir, logic ce, logic [1:0] cr);
    @(negedge clk);
    ev_valid = 1; ev_exc = exc; ev_stk_fault = sf; ev_stk_dir = dir;
    ev_cmp_en = ce; ev_cmp_res = cr;
    @(negedge clk);
    ev_valid = 0; ev_exc = '0; ev_stk_fault = 0; ev_cmp_en = 0;
    m_flags = m_flags | exc | {5'd0, sf};
    m_sf = m_sf | sf;
    if (ce) begin
      case (cr)
        2'd0: m_cc = 4'b0000;
        2'd1: m_cc = 4'b0001;
        2'd2: m_cc = 4'b1000;
        default: m_cc = 4'b1101;
      endcase
    end
    if (sf) m_cc[1] = dir;
  endtask

  task automatic t_reset();
    check("R1 status", status_word, 16'h0000);
    check("R1 mask", {10'd0, mask_out}, 16'h003F);
    check("R1 irq", {15'd0, irq}, 16'h0);
    check("R1 ready", {15'd0, ev_ready}, 16'h1);
  endtask

  task automatic t_masked_flags();
    send(6'b100100, 0, 0, 0, 2'd0);
    check("R2 flags while masked", {8'd0, status_word[7:0]}, 16'h00A4);
    check("R4 summary", {15'd0, status_word[7]}, 16'h1);
    @(negedge clk);
    check("R7 masked no irq", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_sticky();
    send(6'b000010, 0, 0, 0, 2'd0);
    check("R3 accumulate", {8'd0, status_word[7:0]}, {8'd0, low_byte()});
    send(6'b000000, 0, 0, 0, 2'd0);
    check("R3 empty event keeps", {8'd0, status_word[7:0]}, 16'h00A6);
  endtask

  task automatic t_compare();
    for (int r = 0; r < 4; r++) begin
      send(6'd0, 0, 0, 1, 2'(r));
      check($sformatf("R6 compare %0d", r), {12'd0, cc_of(status_word)}, {12'd0, m_cc});
    end
    check("R6 unordered code", {12'd0, cc_of(status_word)}, 16'h000D);
  endtask

  task automatic t_fault();
    send(6'd0, 1, 1, 0, 2'd0);
    check("R5 overflow fault", {8'd0, status_word[7:0]}, {8'd0, low_byte()});
    check("R5 C1 overflow", {15'd0, status_word[9]}, 16'h1);
    send(6'd0, 1, 0, 1, 2'd2);
    check("R5 C1 underflow", {12'd0, cc_of(status_word)}, 16'h0008);
    check("R5 sf bit", {15'd0, status_word[6]}, 16'h1);
  endtask

  task automatic t_unmask();
    @(negedge clk);
    mask_wr = 1; mask_in = 6'h3E;
    @(negedge clk);
    mask_wr = 0;
    check("R12 mask loaded", {10'd0, mask_out}, 16'h003E);
    check("R12 irq not yet", {15'd0, irq}, 16'h0);
    @(negedge clk);
    check("R12 irq after unmask", {15'd0, irq}, 16'h1);
  endtask

  task automatic t_clear();
    logic [3:0] cc_before;
    cc_before = cc_of(status_word);
    @(negedge clk);
    clr_exc = 1;
    @(negedge clk);
    clr_exc = 0;
    m_flags = '0; m_sf = 0;
    check("R8 low byte cleared", {8'd0, status_word[7:0]}, 16'h0000);
    check("R8 irq cleared", {15'd0, irq}, 16'h0);
    check("R8 cc kept", {12'd0, cc_of(status_word)}, {12'd0, cc_before});
    check("R8 mask kept", {10'd0, mask_out}, 16'h003E);
  endtask

  task automatic t_stall();
    @(negedge clk);
    clr_exc = 1; ev_valid = 1; ev_exc = 6'b001000;
    #1;
    check("R10 ready low on clear", {15'd0, ev_ready}, 16'h0);
    @(negedge clk);
    check("R10 event held back", {8'd0, status_word[7:0]}, 16'h0000);
    clr_exc = 0;
    #1;
    check("R10 ready back", {15'd0, ev_ready}, 16'h1);
    @(negedge clk);
    ev_valid = 0; ev_exc = '0;
    m_flags = 6'b001000;
    check("R10 held event applied", {8'd0, status_word[7:0]}, {8'd0, low_byte()});
  endtask

  task automatic t_new_irq();
    send(6'b000001, 0, 0, 0, 2'd0);
    check("R7 not same cycle", {15'd0, irq}, 16'h0);
    @(negedge clk);
    check("R7 unmasked invalid irq", {15'd0, irq}, 16'h1);
  endtask

  task automatic t_init();
    @(negedge clk);
    init = 1;
    @(negedge clk);
    init = 0;
    check("R9 status cleared", status_word, 16'h0000);
    check("R9 masks all set", {10'd0, mask_out}, 16'h003F);
    check("R9 irq cleared", {15'd0, irq}, 16'h0);
    m_flags = '0; m_sf = 0; m_cc = '0;
  endtask

  task automatic t_top_busy();
    @(negedge clk);
    top_in = 3'd5; busy_in = 1;
    #1;
    check("R11 not before edge", {12'd0, status_word[15], status_word[13:11]}, 16'h0000);
    @(negedge clk);
    check("R11 top and busy", {12'd0, status_word[15], status_word[13:11]}, 16'h000D);
    top_in = 3'd2; busy_in = 0;
    @(negedge clk);
    check("R11 follow again", {12'd0, status_word[15], status_word[13:11]}, 16'h0002);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_masked_flags();
    t_sticky();
    t_compare();
    t_fault();
    t_unmask();
    t_clear();
    t_stall();
    t_new_irq();
    t_init();
    t_top_busy();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule